// File: doc/BRIEF.md
# Primitive Actor Execution Unit

This block runs a straight-line program of dataflow actors. Each instruction is one complete actor. When a dispatch pulse arrives, the unit steps through instructions 0 to `prog_len-1` in order, with no branches, loops or jumps. For each actor it reads up to two data operands and one parameter, applies one function in signed Q16.16 fixed point with saturation, and sends the result through that actor's own circular delay line. The delayed value is then written to a destination operand register. Later actors in the same pass read that register, so a chain of actors forms a small dataflow graph that is evaluated once per dispatch.

Each actor's delay line occupies `maxlen+1` words of a shared delay store, starting at the actor's base address. A third operand, tau, sets the delay in dispatches at run time. The delay is clamped to the range 0 to `maxlen`. A delay of zero passes the result straight through in the same pass. The host side loads the instruction store, the parameter table and the operand registers while the unit is idle. It reads results back through the operand port once `done` has pulsed.

The sequencer steps through these states:
- `S_IDLE` goes to `S_FETCH` on dispatch, or to `S_DONE` when the length is zero.
- `S_FETCH` goes to `S_EXEC`.
- `S_EXEC` goes to `S_COMMIT`.
- `S_COMMIT` goes back to `S_FETCH` while instructions remain, and to `S_DONE` after the last one.
- `S_DONE` goes to `S_IDLE`.

Top module: `actor_exec_unit`

## Requirements
- R1: After reset, `busy` and `done` are low, every operand register reads 0 and every delay-store word holds 0.
- R2: Opcode 0 (constant) writes the parameter and ignores both data operands.
- R3: Opcode 1 (multiply-add) gives sat(sat((p*x1)>>>16) + x2).
- R4: Opcode 2 (add) gives the saturating sum x1 + x2.
- R5: Opcode 3 (multiply) gives sat((x1*x2)>>>16).
- R6: Opcode 4 (amplify) gives sat((p*x1)>>>16). Here "sat" clamps to 0x7FFFFFFF / 0x80000000.
- R7: Opcodes 5 to 7 write zero.
- R8: With effective delay d > 0, the value written on dispatch k is the result from dispatch k-d. Slots not yet written read as zero.
- R9: The effective delay is the tau operand read as a signed integer. Negative values give 0, which means the current result is passed on. Values above `maxlen` give `maxlen`.
- R10: Instruction word bits, MSB first, are: [46:44] opcode, [43:38] x1, [37:32] x2, [31:26] tau, [25:20] dst, [19:16] parameter index, [15:8] delay base, [7:0] maxlen. Actors run in address order, and an actor sees results written earlier in the same pass.
- R11: For a program of N instructions, `done` is high for exactly one cycle. It is visible 3N rising edges after the edge that captures the dispatch (N = 0 gives done on that same edge).
- R12: While `busy` is high, a new dispatch and host writes to operands, parameters or instructions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dispatch | input | 1 | Start one pass of the program |
| prog_len | input | 12 | Number of instructions to run |
| imem_we | input | 1 | Instruction store write enable |
| imem_addr | input | 11 | Instruction store address |
| imem_wdata | input | 47 | Instruction word |
| par_we | input | 1 | Parameter table write enable |
| par_addr | input | 4 | Parameter table address |
| par_wdata | input | 32 | Parameter value |
| rf_we | input | 1 | Operand register write enable |
| rf_addr | input | 6 | Operand register address for host read and write |
| rf_wdata | input | 32 | Operand write data |
| rf_rdata | output | 32 | Operand read data (combinational) |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Each actor takes three cycles: fetch, execute and commit. `done` is therefore due exactly 3N rising edges after the edge that captures the dispatch. The bench counts falling edges from that capture edge until `done` appears, and requires `done` to be gone on the next falling edge. Operand results are read combinationally only after `done`, so every read sees all commits of the pass. The delay tests advance one dispatch at a time, so each expected value is simply the parameter from d passes earlier.

// File: rtl/aeu_pkg.sv
`timescale 1ns/1ps
package aeu_pkg;
    parameter int WORD_W  = 32;
    parameter int FRAC_W  = 16;
    parameter int RF_AW   = 6;
    parameter int PAR_AW  = 4;
    parameter int DLY_AW  = 8;
    parameter int IMEM_AW = 11;
    parameter int OP_W    = 3;

    localparam int RF_N   = 1 << RF_AW;
    localparam int PAR_N  = 1 << PAR_AW;
    localparam int DLY_N  = 1 << DLY_AW;
    localparam int IMEM_N = 1 << IMEM_AW;
    localparam int PROD_W = 2 * WORD_W;
    localparam int WIDE_W = 2 * WORD_W + 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_CONST = 3'd0,
        OP_MADD  = 3'd1,
        OP_ADD   = 3'd2,
        OP_MUL   = 3'd3,
        OP_AMP   = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_EXEC,
        S_COMMIT,
        S_DONE
    } state_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [RF_AW-1:0]  x1;
        logic [RF_AW-1:0]  x2;
        logic [RF_AW-1:0]  tau;
        logic [RF_AW-1:0]  dst;
        logic [PAR_AW-1:0] pidx;
        logic [DLY_AW-1:0] dbase;
        logic [DLY_AW-1:0] dmax;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    // Clamp a wide signed value into the signed word range.
    function automatic word_t q_sat(input logic [WIDE_W-1:0] v);
        logic [WORD_W+1:0] top;
        top = v[WIDE_W-1:WORD_W-1];
        if ((&top) || !(|top)) return v[WORD_W-1:0];
        if (v[WIDE_W-1]) return {1'b1, {(WORD_W-1){1'b0}}};
        return {1'b0, {(WORD_W-1){1'b1}}};
    endfunction

    function automatic word_t q_add(input word_t a, input word_t b);
        logic signed [WIDE_W-1:0] s;
        s = WIDE_W'($signed(a)) + WIDE_W'($signed(b));
        return q_sat(s);
    endfunction

    function automatic word_t q_mul(input word_t a, input word_t b);
        logic signed [PROD_W-1:0] ea;
        logic signed [PROD_W-1:0] eb;
        logic signed [PROD_W-1:0] pr;
        logic signed [WIDE_W-1:0] sh;
        ea = PROD_W'($signed(a));
        eb = PROD_W'($signed(b));
        pr = ea * eb;
        sh = WIDE_W'(pr >>> FRAC_W);
        return q_sat(sh);
    endfunction
endpackage

// File: rtl/aeu_func.sv
`timescale 1ns/1ps
module aeu_func
    import aeu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  word_t           par,
    input  word_t           x1,
    input  word_t           x2,
    output word_t           y
);
    always_comb begin
        unique case (op)
            OP_CONST: y = par;
            OP_MADD:  y = q_add(q_mul(par, x1), x2);
            OP_ADD:   y = q_add(x1, x2);
            OP_MUL:   y = q_mul(x1, x2);
            OP_AMP:   y = q_mul(par, x1);
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/aeu_delay.sv
`timescale 1ns/1ps
module aeu_delay
    import aeu_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAME_W-1:0] frame,
    input  logic [DLY_AW-1:0] base,
    input  logic [DLY_AW-1:0] maxlen,
    input  word_t             tau,
    input  word_t             din,
    input  logic              wr_en,
    output logic [DLY_AW-1:0] eff,
    output word_t             dout
);
    localparam int LEN_W = DLY_AW + 1;

    word_t              mem [DLY_N];
    logic [LEN_W-1:0]   ring_len;
    logic [LEN_W-1:0]   wr_slot;
    logic [LEN_W-1:0]   rd_slot;
    logic [FRAME_W-1:0] frame_mod;
    logic [DLY_AW-1:0]  wr_addr;
    logic [DLY_AW-1:0]  rd_addr;

    always_comb begin
        if (tau[WORD_W-1])
            eff = '0;
        else if (tau > WORD_W'(maxlen))
            eff = maxlen;
        else
            eff = tau[DLY_AW-1:0];

        ring_len  = LEN_W'(maxlen) + LEN_W'(1);
        frame_mod = frame % FRAME_W'(ring_len);
        wr_slot   = frame_mod[LEN_W-1:0];

        if (wr_slot >= LEN_W'(eff))
            rd_slot = wr_slot - LEN_W'(eff);
        else
            rd_slot = wr_slot + ring_len - LEN_W'(eff);

        wr_addr = base + wr_slot[DLY_AW-1:0];
        rd_addr = base + rd_slot[DLY_AW-1:0];
        dout    = (eff == '0) ? din : mem[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DLY_N; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= din;
        end
    end
endmodule

// File: rtl/aeu_opstore.sv
`timescale 1ns/1ps
module aeu_opstore
    import aeu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              host_rf_we,
    input  logic [RF_AW-1:0]  host_rf_addr,
    input  word_t             host_rf_wdata,
    output word_t             host_rf_rdata,
    input  logic              host_par_we,
    input  logic [PAR_AW-1:0] host_par_addr,
    input  word_t             host_par_wdata,
    input  logic              eng_we,
    input  logic [RF_AW-1:0]  eng_addr,
    input  word_t             eng_data,
    input  logic [RF_AW-1:0]  x1_addr,
    input  logic [RF_AW-1:0]  x2_addr,
    input  logic [RF_AW-1:0]  tau_addr,
    input  logic [PAR_AW-1:0] par_addr,
    output word_t             x1,
    output word_t             x2,
    output word_t             tau,
    output word_t             par
);
    word_t rf   [RF_N];
    word_t ptab [PAR_N];

    assign x1            = rf[x1_addr];
    assign x2            = rf[x2_addr];
    assign tau           = rf[tau_addr];
    assign par           = ptab[par_addr];
    assign host_rf_rdata = rf[host_rf_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RF_N; i++) rf[i] <= '0;
        end else if (eng_we) begin
            rf[eng_addr] <= eng_data;
        end else if (host_rf_we && !busy) begin
            rf[host_rf_addr] <= host_rf_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAR_N; i++) ptab[i] <= '0;
        end else if (host_par_we && !busy) begin
            ptab[host_par_addr] <= host_par_wdata;
        end
    end
endmodule

// File: rtl/aeu_seq.sv
`timescale 1ns/1ps
module aeu_seq
    import aeu_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dispatch,
    input  logic [IMEM_AW:0]   prog_len,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_addr,
    input  logic [INSTR_W-1:0] imem_wdata,
    input  word_t              result_in,
    output instr_t             instr,
    output word_t              result,
    output logic [FRAME_W-1:0] frame,
    output logic               commit,
    output logic               busy,
    output logic               done
);
    localparam logic [IMEM_AW:0] LEN_MAX = (IMEM_AW+1)'(IMEM_N);

    logic [INSTR_W-1:0] imem [IMEM_N];
    state_e             state_q;
    state_e             state_d;
    logic [IMEM_AW-1:0] pc_q;
    logic [IMEM_AW:0]   len_q;
    logic               last;

    assign last = ((IMEM_AW+1)'(pc_q) + (IMEM_AW+1)'(1)) == len_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (dispatch) state_d = (prog_len == '0) ? S_DONE : S_FETCH;
            S_FETCH:  state_d = S_EXEC;
            S_EXEC:   state_d = S_COMMIT;
            S_COMMIT: state_d = last ? S_DONE : S_FETCH;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy   = (state_q != S_IDLE);
        commit = (state_q == S_COMMIT);
        done   = (state_q == S_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            len_q  <= '0;
            instr  <= '0;
            result <= '0;
            frame  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (dispatch) begin
                    pc_q  <= '0;
                    len_q <= (prog_len > LEN_MAX) ? LEN_MAX : prog_len;
                end
                S_FETCH:  instr  <= imem[pc_q];
                S_EXEC:   result <= result_in;
                S_COMMIT: pc_q   <= pc_q + IMEM_AW'(1);
                S_DONE:   frame  <= frame + FRAME_W'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (imem_we && (state_q == S_IDLE)) imem[imem_addr] <= imem_wdata;
    end
endmodule

// File: rtl/actor_exec_unit.sv
`timescale 1ns/1ps
module actor_exec_unit
    import aeu_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dispatch,
    input  logic [IMEM_AW:0]   prog_len,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_addr,
    input  logic [INSTR_W-1:0] imem_wdata,
    input  logic               par_we,
    input  logic [PAR_AW-1:0]  par_addr,
    input  logic [WORD_W-1:0]  par_wdata,
    input  logic               rf_we,
    input  logic [RF_AW-1:0]   rf_addr,
    input  logic [WORD_W-1:0]  rf_wdata,
    output logic [WORD_W-1:0]  rf_rdata,
    output logic               busy,
    output logic               done
);
    instr_t             ins;
    word_t              fu_y;
    word_t              result_q;
    word_t              op_x1;
    word_t              op_x2;
    word_t              op_tau;
    word_t              op_par;
    word_t              dly_out;
    logic [FRAME_W-1:0] frame;
    logic               commit;
    logic [DLY_AW-1:0]  eff_dly;
    logic [DLY_AW-1:0]  cur_dmax;

    assign cur_dmax = ins.dmax;

    aeu_seq #(.FRAME_W(FRAME_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dispatch   (dispatch),
        .prog_len   (prog_len),
        .imem_we    (imem_we),
        .imem_addr  (imem_addr),
        .imem_wdata (imem_wdata),
        .result_in  (fu_y),
        .instr      (ins),
        .result     (result_q),
        .frame      (frame),
        .commit     (commit),
        .busy       (busy),
        .done       (done)
    );

    aeu_opstore ops_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .busy           (busy),
        .host_rf_we     (rf_we),
        .host_rf_addr   (rf_addr),
        .host_rf_wdata  (rf_wdata),
        .host_rf_rdata  (rf_rdata),
        .host_par_we    (par_we),
        .host_par_addr  (par_addr),
        .host_par_wdata (par_wdata),
        .eng_we         (commit),
        .eng_addr       (ins.dst),
        .eng_data       (dly_out),
        .x1_addr        (ins.x1),
        .x2_addr        (ins.x2),
        .tau_addr       (ins.tau),
        .par_addr       (ins.pidx),
        .x1             (op_x1),
        .x2             (op_x2),
        .tau            (op_tau),
        .par            (op_par)
    );

    aeu_func fu_i (
        .op  (ins.op),
        .par (op_par),
        .x1  (op_x1),
        .x2  (op_x2),
        .y   (fu_y)
    );

    aeu_delay #(.FRAME_W(FRAME_W)) dly_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .frame  (frame),
        .base   (ins.dbase),
        .maxlen (ins.dmax),
        .tau    (op_tau),
        .din    (result_q),
        .wr_en  (commit),
        .eff    (eff_dly),
        .dout   (dly_out)
    );
endmodule

// File: rtl/aeu_chk.sv
`timescale 1ns/1ps
module aeu_chk
    import aeu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dispatch,
    input logic              busy,
    input logic              done,
    input logic              commit,
    input logic [DLY_AW-1:0] eff_dly,
    input logic [DLY_AW-1:0] cur_dmax
);
    // R11: end-of-pass pulse lasts a single cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: the unit is idle right after the end-of-pass pulse
    p_idle_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R12: a pass only starts from a dispatch seen while idle
    p_start_on_dispatch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(dispatch));

    // R9: the delay used at commit never exceeds the actor's maximum
    p_delay_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (eff_dly <= cur_dmax));

    // R10: commits happen only inside a pass
    p_commit_in_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);
endmodule

bind actor_exec_unit aeu_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dispatch (dispatch),
    .busy     (busy),
    .done     (done),
    .commit   (commit),
    .eff_dly  (eff_dly),
    .cur_dmax (cur_dmax)
);

// File: tb/actor_exec_unit_tb_top.sv
`timescale 1ns/1ps
module actor_exec_unit_tb_top;
    import aeu_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               dispatch = 1'b0;
    logic [IMEM_AW:0]   prog_len = '0;
    logic               imem_we = 1'b0;
    logic [IMEM_AW-1:0] imem_addr = '0;
    logic [INSTR_W-1:0] imem_wdata = '0;
    logic               par_we = 1'b0;
    logic [PAR_AW-1:0]  par_addr = '0;
    logic [WORD_W-1:0]  par_wdata = '0;
    logic               rf_we = 1'b0;
    logic [RF_AW-1:0]   rf_addr = '0;
    logic [WORD_W-1:0]  rf_wdata = '0;
    logic [WORD_W-1:0]  rf_rdata;
    logic               busy;
    logic               done;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    actor_exec_unit dut_i (.*);

    // op, param, x1, x2, expected
    localparam int NV = 10;
    localparam logic [130:0] VEC [NV] = '{
        {3'd0, 32'h0003_0000, 32'h1111_1111, 32'h2222_2222, 32'h0003_0000},
        {3'd1, 32'h0002_0000, 32'h0001_8000, 32'h0001_0000, 32'h0004_0000},
        {3'd1, 32'h7FFF_0000, 32'h0002_0000, 32'h0001_0000, 32'h7FFF_FFFF},
        {3'd2, 32'h0000_0000, 32'h0001_8000, 32'h0002_0000, 32'h0003_8000},
        {3'd2, 32'h0000_0000, 32'h7FFF_0000, 32'h0002_0000, 32'h7FFF_FFFF},
        {3'd2, 32'h0000_0000, 32'h8000_0000, 32'hFFFF_0000, 32'h8000_0000},
        {3'd3, 32'h0000_0000, 32'h0001_8000, 32'h0002_0000, 32'h0003_0000},
        {3'd3, 32'h0000_0000, 32'h0100_0000, 32'hFF00_0000, 32'h8000_0000},
        {3'd4, 32'hFFFF_8000, 32'h0004_0000, 32'h5555_5555, 32'hFFFE_0000},
        {3'd7, 32'h0001_0000, 32'h0000_0001, 32'h0000_0002, 32'h0000_0000}
    };

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [INSTR_W-1:0] mk(input logic [2:0] op, input int x1, input int x2,
                                              input int tau, input int dst, input int pidx,
                                              input int dbase, input int dmax);
        return {op, 6'(x1), 6'(x2), 6'(tau), 6'(dst), 4'(pidx), 8'(dbase), 8'(dmax)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_tb();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic wr_rf(input int a, input logic [31:0] d);
        @(negedge clk); rf_we = 1'b1; rf_addr = 6'(a); rf_wdata = d;
        @(negedge clk); rf_we = 1'b0;
    endtask

    task automatic wr_par(input int a, input logic [31:0] d);
        @(negedge clk); par_we = 1'b1; par_addr = 4'(a); par_wdata = d;
        @(negedge clk); par_we = 1'b0;
    endtask

    task automatic wr_im(input int a, input logic [INSTR_W-1:0] d);
        @(negedge clk); imem_we = 1'b1; imem_addr = 11'(a); imem_wdata = d;
        @(negedge clk); imem_we = 1'b0;
    endtask

    task automatic rd_rf(input int a, output logic [31:0] d);
        rf_addr = 6'(a);
        #1 d = rf_rdata;
    endtask

    // R11: runs N instructions and checks done latency and width
    task automatic run(input int n);
        int cyc;
        @(negedge clk); prog_len = 12'(n); dispatch = 1'b1;
        @(negedge clk); dispatch = 1'b0;
        cyc = 0;
        while (!done && cyc < 3 * n + 20) begin
            @(negedge clk); cyc++;
        end
        check("R11 done latency", 32'(cyc), 32'(3 * n));
        @(negedge clk);
        check("R11 done width", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_tb();
    end

    initial begin
        logic [31:0] v;
        int dcount;
        logic [31:0] pv [6];
        logic [31:0] ev [6];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        rd_rf(10, v);
        check("R1 operand", v, 32'd0);

        // R2..R7 function table
        for (int i = 0; i < NV; i++) begin
            wr_rf(1, VEC[i][95:64]);
            wr_rf(2, VEC[i][63:32]);
            wr_rf(3, 32'd0);
            wr_par(0, VEC[i][127:96]);
            wr_im(0, mk(VEC[i][130:128], 1, 2, 3, 10, 0, 0, 0));
            run(1);
            rd_rf(10, v);
            check(op_req(VEC[i][130:128]), v, VEC[i][31:0]);
        end

        // R8 / R9 delay line: constant actor, base 16, max 3
        wr_im(0, mk(3'd0, 1, 2, 4, 20, 1, 16, 3));
        wr_rf(4, 32'd2);
        pv = '{32'd100, 32'd200, 32'd300, 32'd400, 32'd500, 32'd600};
        ev = '{32'd0,   32'd0,   32'd100, 32'd200, 32'd200, 32'd600};
        for (int k = 0; k < 6; k++) begin
            if (k == 4) wr_rf(4, 32'd10);
            if (k == 5) wr_rf(4, 32'hFFFF_FFFF);
            wr_par(1, pv[k]);
            run(1);
            rd_rf(20, v);
            check((k < 4) ? "R8 delayed output" : "R9 tau clamp", v, ev[k]);
        end

        // R10 ordered chain: add into r30, amplify r30 into r31
        wr_rf(1, 32'h0001_0000);
        wr_rf(2, 32'h0002_0000);
        wr_rf(3, 32'd0);
        wr_par(2, 32'h0000_8000);
        wr_im(0, mk(3'd2, 1, 2, 3, 30, 0, 0, 0));
        wr_im(1, mk(3'd4, 30, 2, 3, 31, 2, 0, 0));
        run(2);
        rd_rf(30, v);
        check("R10 first actor", v, 32'h0003_0000);
        rd_rf(31, v);
        check("R10 chained actor", v, 32'h0001_8000);

        // R11 empty program
        run(0);

        // R12 dispatch and host write ignored while busy
        @(negedge clk); prog_len = 12'd2; dispatch = 1'b1;
        @(negedge clk); dispatch = 1'b0;
        dcount = 0;
        @(negedge clk);
        check("R12 busy", 32'(busy), 32'd1);
        dispatch = 1'b1; rf_we = 1'b1; rf_addr = 6'd1; rf_wdata = 32'h0001_2345;
        if (done) dcount++;
        @(negedge clk); dispatch = 1'b0; rf_we = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (done) dcount++;
            @(negedge clk);
        end
        check("R12 extra dispatch", 32'(dcount), 32'd1);
        rd_rf(1, v);
        check("R12 host write", v, 32'h0001_0000);

        finish_tb();
    end
endmodule